// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a 32K x 8 asynchronous static RAM. The user side has a request/acknowledge port. A request carries a 15-bit address, 8-bit write data and a read/write flag. The user holds the request high until the acknowledge pulse comes back. On the memory side the block drives three active-low strobes (chip select, output enable, write strobe) and the address bus. The common data bus is handled by pad-level tri-state control: an output value, an output enable and an input value.

The memory has no clock, so every timing rule is met by counting clock cycles. Each interval is a parameter in picoseconds: read access, write pulse width, data setup before the end of the write strobe, and bus release after output enable rises. Each is divided by the clock period and rounded up. A read keeps the part selected with outputs enabled for the full access window and captures the bus on the last cycle of that window. A write pulls the write strobe low for the longer of the pulse-width and data-setup counts, with output enable held high. When a write follows a read, idle turnaround cycles are inserted before the controller turns on its own data drivers. Between requests the part is deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request, sram_ce_n, sram_oe_n and sram_we_n are 1, dq_oe is 0, ack is 0 and rdata is 0.
- R2: A read drives sram_ce_n=0, sram_oe_n=0, sram_we_n=1 and sram_addr equal to the request address for exactly ACC_CYC consecutive cycles, beginning in the cycle after the request is seen in idle.
- R3: rdata holds the dq_in value sampled at the last clock edge of the read access window, and it is valid in the acknowledge cycle.
- R4: A write drives sram_ce_n=0, sram_we_n=0, sram_oe_n=1, dq_oe=1 and dq_out equal to the request data for exactly STROBE_CYC cycles, where STROBE_CYC is the larger of the pulse-width and data-setup counts.
- R5: After the write strobe rises, dq_oe and dq_out stay unchanged for one more cycle (zero-hold margin). In that cycle sram_ce_n=1 and ack=1.
- R6: ack is high for exactly one cycle per request, in the cycle after the read window or write strobe ends. After that cycle the strobes return to the idle values of R1.
- R7: dq_oe is never 1 while sram_oe_n is 0, and sram_we_n is never 0 while sram_oe_n is 0.
- R8: When a write follows a read, the block holds the idle strobe values for TURN_CYC cycles after its idle cycle before it lowers the write strobe. As a result, at least TURN_CYC+1 cycles with sram_oe_n=1 come before dq_oe rises.
- R9: req, req_wr, req_addr and req_wdata are sampled only in idle. Changes to them during an access do not alter sram_addr, dq_out or the operation in progress.
- R10: Each cycle count is the ceiling of its picosecond parameter divided by CLK_PERIOD_PS, with a minimum of 1. ACC_CYC comes from the access time, STROBE_CYC from the maximum of the pulse-width and setup counts, and TURN_CYC from the release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Captured read data |
| ack | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_addr | output | ADDR_W | Memory address bus |
| dq_out | output | DATA_W | Data value driven toward the memory |
| dq_oe | output | 1 | Enable of the controller's data drivers |
| dq_in | input | DATA_W | Data bus value seen at the pad |

## Verification
The assertions check these properties on every cycle:
- the output-enable and write-strobe low windows have exactly the derived lengths;
- the controller never drives the bus while the memory may be driving it;
- the address and write data stay stable while the part is selected or being driven;
- acknowledge never lasts two cycles;
- the release gap before drivers turn on after a read is respected.

Only the bench scenarios can show three other behaviours. The first is that read data really comes from the last access edge: the memory model returns poison data earlier than that. The second is that requests scrambled mid-access are ignored. The third is that the data written is the data later read back, including at the lowest and highest addresses and for an address never written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RACC,
      ST_RDONE,
      ST_TURN,
      ST_WPULSE,
      ST_WEND
   } ctrl_state_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
      logic ack;
   } strobe_t;

   // ceiling of t_ps / clk_ps, never below one cycle
   function automatic int cycles_for(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // a loaded count never grows without a new load
   assert_timer_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(!load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lat_en,
   input  logic              cap_en,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   // request fields are latched only on acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (lat_en) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   // read capture register, loaded on the last access edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (cap_en)
         rdata_q <= dq_in;
   end

   assign sram_addr = addr_q;
   assign dq_out    = wdata_q;
   assign rdata     = rdata_q;

   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cap_en) |-> $stable(rdata_q));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ACC_CYC    = 2,
   parameter int STROBE_CYC = 1,
   parameter int TURN_CYC   = 1,
   parameter int CNT_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_wr,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             lat_en,
   output logic             cap_en,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe,
   output logic             ack
);

   localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] STR_LD  = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
   localparam logic [CNT_W:0]   REL_SAT = (CNT_W+1)'(TURN_CYC + 2);
   localparam logic [CNT_W:0]   REL_MIN = (CNT_W+1)'(TURN_CYC + 1);

   ctrl_state_e state_q, nxt;
   logic        last_rd_q;
   strobe_t     strb_d, strb_q;

   always_comb begin
      nxt      = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      lat_en   = 1'b0;
      cap_en   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               lat_en   = 1'b1;
               tmr_load = 1'b1;
               if (!req_wr) begin
                  tmr_val = ACC_LD;
                  nxt     = ST_RACC;
               end else if (last_rd_q) begin
                  tmr_val = TURN_LD;
                  nxt     = ST_TURN;
               end else begin
                  tmr_val = STR_LD;
                  nxt     = ST_WPULSE;
               end
            end
         end
         ST_RACC: begin
            if (tmr_done) begin
               cap_en = 1'b1;
               nxt    = ST_RDONE;
            end
         end
         ST_RDONE: nxt = ST_IDLE;
         ST_TURN: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               tmr_val  = STR_LD;
               nxt      = ST_WPULSE;
            end
         end
         ST_WPULSE: begin
            if (tmr_done) nxt = ST_WEND;
         end
         ST_WEND: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   // strobe pattern of the state about to be entered, registered below
   always_comb begin
      unique case (nxt)
         ST_RACC:   strb_d = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};
         ST_RDONE:  strb_d = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ack: 1'b1};
         ST_WPULSE: strb_d = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1, ack: 1'b0};
         ST_WEND:   strb_d = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1, ack: 1'b1};
         default:   strb_d = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
         strb_q    <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};
      end else begin
         state_q <= nxt;
         strb_q  <= strb_d;
         if (cap_en)
            last_rd_q <= 1'b1;
         else if (nxt == ST_WPULSE && state_q != ST_WPULSE)
            last_rd_q <= 1'b0;
      end
   end

   assign ce_n  = strb_q.ce_n;
   assign oe_n  = strb_q.oe_n;
   assign we_n  = strb_q.we_n;
   assign dq_oe = strb_q.dq_oe;
   assign ack   = strb_q.ack;

   // cycles since output enable last rose, saturating
   logic [CNT_W:0] rel_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rel_cnt_q <= REL_SAT;
      else if (!oe_n)
         rel_cnt_q <= '0;
      else if (rel_cnt_q != REL_SAT)
         rel_cnt_q <= rel_cnt_q + 1'b1;
   end

   assert_no_bus_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && dq_oe));
   assert_we_oe_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));
   assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> (rel_cnt_q >= REL_MIN));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int T_ACCESS_PS   = 12000,
   parameter int T_WPULSE_PS   = 9000,
   parameter int T_DSETUP_PS   = 8000,
   parameter int T_RELEASE_PS  = 6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ack,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in
);

   localparam int ACC_CYC    = cycles_for(T_ACCESS_PS, CLK_PERIOD_PS);
   localparam int WP_CYC     = cycles_for(T_WPULSE_PS, CLK_PERIOD_PS);
   localparam int DS_CYC     = cycles_for(T_DSETUP_PS, CLK_PERIOD_PS);
   localparam int STROBE_CYC = max2(WP_CYC, DS_CYC);
   localparam int TURN_CYC   = cycles_for(T_RELEASE_PS, CLK_PERIOD_PS);
   localparam int LONGEST    = max2(ACC_CYC, max2(STROBE_CYC, TURN_CYC));
   localparam int CNT_W      = max2(1, $clog2(LONGEST + 1));

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: bus widths must be positive");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clock
         $error("sram_async_ctrl: clock period must be positive");
      end
      if (T_ACCESS_PS < 0 || T_WPULSE_PS < 0 || T_DSETUP_PS < 0 || T_RELEASE_PS < 0) begin : g_bad_time
         $error("sram_async_ctrl: timing intervals must not be negative");
      end
   endgenerate

   logic             tmr_load, tmr_done, lat_en, cap_en;
   logic [CNT_W-1:0] tmr_val;

   sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_ctrl_fsm #(
      .ACC_CYC    (ACC_CYC),
      .STROBE_CYC (STROBE_CYC),
      .TURN_CYC   (TURN_CYC),
      .CNT_W      (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_wr   (req_wr),
      .tmr_done (tmr_done),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .lat_en   (lat_en),
      .cap_en   (cap_en),
      .ce_n     (sram_ce_n),
      .oe_n     (sram_oe_n),
      .we_n     (sram_we_n),
      .dq_oe    (dq_oe),
      .ack      (ack)
   );

   sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_en    (lat_en),
      .cap_en    (cap_en),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (dq_in),
      .sram_addr (sram_addr),
      .dq_out    (dq_out),
      .rdata     (rdata)
   );

   // low-window length monitors for the strobe checks
   logic [15:0] oe_lo_cnt_q, we_lo_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_lo_cnt_q <= '0;
         we_lo_cnt_q <= '0;
      end else begin
         oe_lo_cnt_q <= sram_oe_n ? 16'd0 : oe_lo_cnt_q + 16'd1;
         we_lo_cnt_q <= sram_we_n ? 16'd0 : we_lo_cnt_q + 16'd1;
      end
   end

   assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> (oe_lo_cnt_q == 16'(ACC_CYC)));
   assert_write_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_lo_cnt_q == 16'(STROBE_CYC)));
   assert_hold_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> dq_oe);
   assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
   assert_wdata_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TB_CLK_PS  = 10000;
   localparam int ACC_PS     = 25000;
   localparam int WP_PS      = 9000;
   localparam int DS_PS      = 15000;
   localparam int REL_PS     = 12000;
   // expected counts, rounded up from the intervals (R10)
   localparam int E_ACC  = (ACC_PS + TB_CLK_PS - 1) / TB_CLK_PS;
   localparam int E_WP   = (WP_PS + TB_CLK_PS - 1) / TB_CLK_PS;
   localparam int E_DS   = (DS_PS + TB_CLK_PS - 1) / TB_CLK_PS;
   localparam int E_STR  = (E_WP > E_DS) ? E_WP : E_DS;
   localparam int E_TURN = (REL_PS + TB_CLK_PS - 1) / TB_CLK_PS;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req, req_wr;
   logic [14:0] req_addr;
   logic [7:0]  req_wdata;
   logic [7:0]  rdata;
   logic        ack, sram_ce_n, sram_oe_n, sram_we_n, dq_oe;
   logic [14:0] sram_addr;
   logic [7:0]  dq_out;
   logic [7:0]  dq_in_r;

   int n_tests = 0;
   int n_fail  = 0;
   bit last_rd = 1'b0;
   int oe_run  = 0;
   int we_run  = 0;
   int acc_cnt = 0;
   logic mem_drv;

   logic [7:0] sram_mem [int];
   logic [7:0] gold [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_async_ctrl #(
      .ADDR_W(15), .DATA_W(8), .CLK_PERIOD_PS(TB_CLK_PS),
      .T_ACCESS_PS(ACC_PS), .T_WPULSE_PS(WP_PS),
      .T_DSETUP_PS(DS_PS), .T_RELEASE_PS(REL_PS)
   ) u_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .ack(ack),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_addr(sram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in_r)
   );

   function automatic logic [7:0] blank(input int a);
      return {a[3:0], a[7:4]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] mem_rd(input int a);
      if (sram_mem.exists(a)) return sram_mem[a];
      return blank(a);
   endfunction

   function automatic logic [7:0] gold_rd(input int a);
      if (gold.exists(a)) return gold[a];
      return blank(a);
   endfunction

   assign mem_drv = !sram_ce_n && !sram_oe_n && sram_we_n;

   // memory model: writes while selected and strobed, data poisoned until access time
   always @(posedge clk) begin
      if (mem_drv) acc_cnt <= acc_cnt + 1;
      else         acc_cnt <= 0;
      if (!sram_ce_n && !sram_we_n && dq_oe) sram_mem[int'(sram_addr)] = dq_out;
   end

   always @(negedge clk) begin
      if (mem_drv)
         dq_in_r = (acc_cnt >= E_ACC - 1) ? mem_rd(int'(sram_addr)) : 8'hEE;
      else
         dq_in_r = dq_oe ? dq_out : 8'h00;
      if (!sram_oe_n) oe_run = oe_run + 1;
      if (!sram_we_n) we_run = we_run + 1;
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one reference cycle: compare every output against the expected pattern
   task automatic step(input logic e_ce, input logic e_oe, input logic e_we,
                       input logic e_doe, input logic e_ack,
                       input logic [14:0] e_addr, input logic [7:0] e_d,
                       input string tag);
      logic [4:0] act, exp;
      @(negedge clk);
      act = {sram_ce_n, sram_oe_n, sram_we_n, dq_oe, ack};
      exp = {e_ce, e_oe, e_we, e_doe, e_ack};
      check(act == exp, tag, "strobes", int'(act), int'(exp));
      if (!e_ce) check(sram_addr == e_addr, tag, "address", int'(sram_addr), int'(e_addr));
      if (e_doe) check(dq_out == e_d, tag, "write data", int'(dq_out), int'(e_d));
      check(!(dq_oe && mem_drv), "R7", "bus contention", int'(dq_oe), 0);
      // R9: scramble request fields while the access runs
      if (req) begin
         req_addr  = ~req_addr;
         req_wdata = ~req_wdata;
         req_wr    = ~req_wr;
      end
   endtask

   task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
      oe_run    = 0;
      we_run    = 0;
      req       = 1'b1;
      req_wr    = wr;
      req_addr  = a;
      req_wdata = d;
      if (!wr) begin
         for (int i = 0; i < E_ACC; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, d, "R2");
         step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, a, d, "R6");
         check(rdata == gold_rd(int'(a)), "R3", "read data", int'(rdata), int'(gold_rd(int'(a))));
         req = 1'b0;
         step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d, "R6");
         check(oe_run == E_ACC, "R10", "access cycles", oe_run, E_ACC);
         last_rd = 1'b1;
      end else begin
         if (last_rd)
            for (int i = 0; i < E_TURN; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d, "R8");
         for (int i = 0; i < E_STR; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d, "R4");
         step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, a, d, "R5");
         req = 1'b0;
         step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d, "R6");
         check(we_run == E_STR, "R10", "strobe cycles", we_run, E_STR);
         gold[int'(a)] = d;
         last_rd = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R6 watchdog: actual no completion expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req       = 1'b0;
      req_wr    = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check({sram_ce_n, sram_oe_n, sram_we_n, dq_oe, ack} == 5'b11100, "R1", "reset strobes",
               int'({sram_ce_n, sram_oe_n, sram_we_n, dq_oe, ack}), 'h1C);
         check(rdata == 8'h00, "R1", "reset rdata", int'(rdata), 0);
      end
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, "R1");

      do_op(1'b1, 15'h0123, 8'hA5);   // write, no prior read
      do_op(1'b1, 15'h0124, 8'h3C);   // back-to-back write
      do_op(1'b0, 15'h0123, 8'h00);   // read after write
      do_op(1'b0, 15'h0124, 8'h00);   // read after read
      do_op(1'b1, 15'h0123, 8'h99);   // write after read: turnaround (R8)
      do_op(1'b0, 15'h0123, 8'h00);
      do_op(1'b0, 15'h2222, 8'h00);   // never written
      do_op(1'b1, 15'h0000, 8'h01);   // lowest address
      do_op(1'b1, 15'h7FFF, 8'hFE);   // highest address
      do_op(1'b0, 15'h7FFF, 8'h00);
      do_op(1'b0, 15'h0000, 8'h00);
      for (int i = 0; i < 8; i++) begin
         do_op(i[0], 15'(i * 37 + 5), 8'(i * 29 + 3));
      end
      for (int i = 0; i < 8; i++) begin
         do_op(1'b0, 15'(i * 37 + 5), 8'h00);
      end

      summary();
      $finish;
   end

endmodule